// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address. It reads the translation tree from memory, one 4-byte entry at a time, through a simple request/grant/response port. The tree has two levels. The top 10 bits of the virtual address select an entry in the directory table, and the directory table's page frame comes from a root register. The next 10 bits select an entry in a leaf table. The low 12 bits pass through unchanged as the offset within a 4 KB page. Each table holds 1024 entries and so fills exactly one page.

A directory entry can also map a 4 MB region directly. In that case the walk stops after one read, and the low 22 bits of the virtual address form the offset. Before a walk reports success, it checks the final entry for presence, user access and write permission. It then writes that entry back with its accessed flag set, and with its dirty flag set as well when the access was a store. A faulting walk reports one of three fault codes and writes nothing. The walker runs one walk at a time. Changing the address space only needs a new value in the root register.

Entry bit layout, used at both levels: bit 0 present, bit 1 writeable, bit 2 user-accessible, bit 5 accessed, bit 6 dirty, bit 7 large page (directory level only), bits 31:12 frame number.

Top module: `pt_walker`

## Requirements
- R1: After reset, req_ready is 1, mem_req_valid is 0 and done_valid is 0.
- R2: The first read of a walk goes to {root frame, VA[31:22], 2'b00}, using the root frame held when the request was accepted.
- R3: If the directory entry has bit 0 = 1 and bit 7 = 0, the second read goes to {directory entry[31:12], VA[21:12], 2'b00}.
- R4: A successful two-read walk returns done_paddr = {leaf entry[31:12], VA[11:0]} with done_fault = 0.
- R5: If the directory entry has bit 0 = 1 and bit 7 = 1, the walk does exactly one read and returns done_paddr = {directory entry[31:22], VA[21:0]}.
- R6: If bit 0 is clear in the entry read at either level, the walk ends with done_fault = 1 (not present) and makes no further memory access.
- R7: A user access (req_user = 1) to a final entry with bit 2 clear ends with done_fault = 3. This check takes priority over the write check.
- R8: A store (req_store = 1) to a final entry with bit 1 clear ends with done_fault = 2.
- R9: On success, before done_valid, the walker writes the final entry back to the address it was read from. Bit 5 is set, bit 6 is set if the access was a store, and every other bit is unchanged.
- R10: A faulting walk writes no memory and returns done_paddr = 0.
- R11: req_ready is 1 only when no walk is running. A req_valid presented while busy is ignored. Each accepted request yields exactly one done_valid pulse.
- R12: A memory request keeps its valid, write, address and data stable until mem_gnt. Each granted request waits for one mem_rsp_valid before the walk moves on.
- R13: Writing root_frame with root_we changes the directory table used by every walk accepted in a later cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| root_we | input | 1 | Load the root register |
| root_frame | input | 20 | Frame number of the directory table |
| req_valid | input | 1 | Translation request |
| req_ready | output | 1 | Walker idle, request accepted this cycle |
| req_vaddr | input | 32 | Virtual address to translate |
| req_store | input | 1 | Access is a store |
| req_user | input | 1 | Access is from user mode |
| mem_req_valid | output | 1 | Memory access pending |
| mem_req_write | output | 1 | Pending access is a write |
| mem_req_addr | output | 32 | Byte address of the entry |
| mem_req_wdata | output | 32 | Entry value to write |
| mem_gnt | input | 1 | Memory takes the pending access |
| mem_rsp_valid | input | 1 | Read data or write completion |
| mem_rsp_rdata | input | 32 | Entry read from memory |
| done_valid | output | 1 | One-cycle result strobe |
| done_paddr | output | 32 | Physical address (0 on fault) |
| done_fault | output | 2 | 0 ok, 1 not present, 2 write protect, 3 user protect |

## Verification
The assertions assume that memory answers each granted access with exactly one mem_rsp_valid, one or more cycles after the grant, and never sends a response without a pending access. They also assume that mem_gnt can stall a request for any number of cycles. The bench memory model answers exactly one cycle after each grant. In one scenario it grants only on alternate cycles, to keep requests waiting. Requests are issued only when req_ready is high, except in the scenario that checks requests arriving while the walker is busy. Root register writes happen only while the walker is idle.

// File: rtl/pt_walk_pkg.sv
package pt_walk_pkg;

    localparam int unsigned B_VALID = 0;
    localparam int unsigned B_WR    = 1;
    localparam int unsigned B_USER  = 2;
    localparam int unsigned B_ACC   = 5;
    localparam int unsigned B_DIRTY = 6;
    localparam int unsigned B_HUGE  = 7;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DIR_REQ,
        ST_DIR_WAIT,
        ST_LEAF_REQ,
        ST_LEAF_WAIT,
        ST_WB_REQ,
        ST_WB_WAIT,
        ST_DONE
    } walk_state_e;

    typedef enum logic [1:0] {
        FLT_NONE   = 2'd0,
        FLT_ABSENT = 2'd1,
        FLT_WRITE  = 2'd2,
        FLT_USER   = 2'd3
    } fault_e;

endpackage

// File: rtl/pt_addr_gen.sv
module pt_addr_gen #(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned OFF_W  = 12,
    parameter int unsigned IDX_W  = 10
) (
    input  logic [ADDR_W-OFF_W-1:0] root_frame,
    input  logic [ADDR_W-1:0]       vaddr,
    input  logic [ADDR_W-OFF_W-1:0] resp_frame,
    output logic [ADDR_W-1:0]       dir_addr,
    output logic [ADDR_W-1:0]       leaf_addr,
    output logic [ADDR_W-1:0]       small_pa,
    output logic [ADDR_W-1:0]       big_pa
);
    localparam int unsigned ESZ   = $clog2(ADDR_W / 8);
    localparam int unsigned BIG_W = OFF_W + IDX_W;
    localparam int unsigned TOP_W = ADDR_W - BIG_W;

    logic [IDX_W-1:0] dir_idx;
    logic [IDX_W-1:0] leaf_idx;

    assign dir_idx  = vaddr[ADDR_W-1 -: IDX_W];
    assign leaf_idx = vaddr[BIG_W-1 -: IDX_W];

    // table base is a page frame, entry index scaled by entry size
    assign dir_addr  = {root_frame, {OFF_W{1'b0}}} | (ADDR_W'(dir_idx) << ESZ);
    assign leaf_addr = {resp_frame, {OFF_W{1'b0}}} | (ADDR_W'(leaf_idx) << ESZ);

    assign small_pa = {resp_frame, vaddr[OFF_W-1:0]};
    assign big_pa   = {resp_frame[ADDR_W-OFF_W-1 -: TOP_W], vaddr[BIG_W-1:0]};

endmodule

// File: rtl/pt_entry_check.sv
module pt_entry_check
    import pt_walk_pkg::*;
#(
    parameter int unsigned ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] entry,
    input  logic              at_dir,
    input  logic              is_store,
    input  logic              is_user,
    output fault_e            fault,
    output logic              descend,
    output logic [ADDR_W-1:0] wb_word
);
    always_comb begin
        fault   = FLT_NONE;
        descend = 1'b0;
        if (!entry[B_VALID]) begin
            fault = FLT_ABSENT;
        end else if (at_dir && !entry[B_HUGE]) begin
            descend = 1'b1;
        end else if (is_user && !entry[B_USER]) begin
            fault = FLT_USER;
        end else if (is_store && !entry[B_WR]) begin
            fault = FLT_WRITE;
        end
    end

    always_comb begin
        wb_word        = entry;
        wb_word[B_ACC] = 1'b1;
        if (is_store) begin
            wb_word[B_DIRTY] = 1'b1;
        end
    end

endmodule

// File: rtl/pt_walker.sv
module pt_walker
    import pt_walk_pkg::*;
#(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned OFF_W  = 12,
    parameter int unsigned IDX_W  = 10,
    parameter logic [ADDR_W-OFF_W-1:0] ROOT_RST = '0
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    root_we,
    input  logic [ADDR_W-OFF_W-1:0] root_frame,
    input  logic                    req_valid,
    output logic                    req_ready,
    input  logic [ADDR_W-1:0]       req_vaddr,
    input  logic                    req_store,
    input  logic                    req_user,
    output logic                    mem_req_valid,
    output logic                    mem_req_write,
    output logic [ADDR_W-1:0]       mem_req_addr,
    output logic [ADDR_W-1:0]       mem_req_wdata,
    input  logic                    mem_gnt,
    input  logic                    mem_rsp_valid,
    input  logic [ADDR_W-1:0]       mem_rsp_rdata,
    output logic                    done_valid,
    output logic [ADDR_W-1:0]       done_paddr,
    output logic [1:0]              done_fault
);
    localparam int unsigned FRAME_W = ADDR_W - OFF_W;

    typedef struct packed {
        walk_state_e         st;
        logic [ADDR_W-1:0]   va;
        logic                store;
        logic                user;
        logic [FRAME_W-1:0]  root;
        logic [ADDR_W-1:0]   ea;
        logic [ADDR_W-1:0]   ent;
        logic [ADDR_W-1:0]   pa;
        fault_e              flt;
    } walk_regs_t;

    walk_regs_t r_d, r_q;

    logic [ADDR_W-1:0] va_sel;
    logic [ADDR_W-1:0] dir_addr, leaf_addr, small_pa, big_pa;
    logic [ADDR_W-1:0] wb_word;
    fault_e            chk_fault;
    logic              chk_descend;

    assign va_sel = (r_q.st == ST_IDLE) ? req_vaddr : r_q.va;

    pt_addr_gen #(
        .ADDR_W (ADDR_W),
        .OFF_W  (OFF_W),
        .IDX_W  (IDX_W)
    ) u_addr (
        .root_frame (r_q.root),
        .vaddr      (va_sel),
        .resp_frame (mem_rsp_rdata[ADDR_W-1:OFF_W]),
        .dir_addr   (dir_addr),
        .leaf_addr  (leaf_addr),
        .small_pa   (small_pa),
        .big_pa     (big_pa)
    );

    pt_entry_check #(
        .ADDR_W (ADDR_W)
    ) u_check (
        .entry    (mem_rsp_rdata),
        .at_dir   (r_q.st == ST_DIR_WAIT),
        .is_store (r_q.store),
        .is_user  (r_q.user),
        .fault    (chk_fault),
        .descend  (chk_descend),
        .wb_word  (wb_word)
    );

    always_comb begin
        r_d = r_q;
        unique case (r_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    r_d.st    = ST_DIR_REQ;
                    r_d.va    = req_vaddr;
                    r_d.store = req_store;
                    r_d.user  = req_user;
                    r_d.ea    = dir_addr;
                    r_d.pa    = '0;
                    r_d.flt   = FLT_NONE;
                end
            end
            ST_DIR_REQ: begin
                if (mem_gnt) r_d.st = ST_DIR_WAIT;
            end
            ST_DIR_WAIT: begin
                if (mem_rsp_valid) begin
                    if (chk_fault != FLT_NONE) begin
                        r_d.flt = chk_fault;
                        r_d.st  = ST_DONE;
                    end else if (chk_descend) begin
                        r_d.ea = leaf_addr;
                        r_d.st = ST_LEAF_REQ;
                    end else begin
                        r_d.pa  = big_pa;
                        r_d.ent = wb_word;
                        r_d.st  = ST_WB_REQ;
                    end
                end
            end
            ST_LEAF_REQ: begin
                if (mem_gnt) r_d.st = ST_LEAF_WAIT;
            end
            ST_LEAF_WAIT: begin
                if (mem_rsp_valid) begin
                    if (chk_fault != FLT_NONE) begin
                        r_d.flt = chk_fault;
                        r_d.st  = ST_DONE;
                    end else begin
                        r_d.pa  = small_pa;
                        r_d.ent = wb_word;
                        r_d.st  = ST_WB_REQ;
                    end
                end
            end
            ST_WB_REQ: begin
                if (mem_gnt) r_d.st = ST_WB_WAIT;
            end
            ST_WB_WAIT: begin
                if (mem_rsp_valid) r_d.st = ST_DONE;
            end
            ST_DONE: begin
                r_d.st = ST_IDLE;
            end
            default: r_d.st = ST_IDLE;
        endcase
        if (root_we) begin
            r_d.root = root_frame;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q       <= '0;
            r_q.st    <= ST_IDLE;
            r_q.flt   <= FLT_NONE;
            r_q.root  <= ROOT_RST;
        end else begin
            r_q <= r_d;
        end
    end

    assign req_ready     = (r_q.st == ST_IDLE);
    assign mem_req_valid = (r_q.st == ST_DIR_REQ) || (r_q.st == ST_LEAF_REQ) ||
                           (r_q.st == ST_WB_REQ);
    assign mem_req_write = (r_q.st == ST_WB_REQ);
    assign mem_req_addr  = r_q.ea;
    assign mem_req_wdata = r_q.ent;
    assign done_valid    = (r_q.st == ST_DONE);
    assign done_paddr    = r_q.pa;
    assign done_fault    = r_q.flt;

    // Tracks whether the running walk has had a write granted.
    logic wrote_q;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wrote_q <= 1'b0;
        end else if (req_valid && req_ready) begin
            wrote_q <= 1'b0;
        end else if (mem_req_valid && mem_req_write && mem_gnt) begin
            wrote_q <= 1'b1;
        end
    end

    a_r12_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && !mem_gnt |=> mem_req_valid && $stable(mem_req_addr) &&
            $stable(mem_req_wdata) && $stable(mem_req_write));

    a_r11_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready |=> !req_ready);

    a_r10_fault_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        done_valid && (done_fault != 2'd0) |-> !wrote_q && (done_paddr == '0));

    a_r9_success_wrote: assert property (@(posedge clk) disable iff (!rst_n)
        done_valid && (done_fault == 2'd0) |-> wrote_q);

    a_r9_wb_accessed: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && mem_req_write |-> mem_req_wdata[B_ACC] && mem_req_wdata[B_VALID]);

    a_r11_single_done: assert property (@(posedge clk) disable iff (!rst_n)
        done_valid |=> !done_valid && req_ready);

endmodule

// File: tb/sim_pt_walker.sv
`timescale 1ns/1ps
module sim_pt_walker;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        root_we = 1'b0;
    logic [19:0] root_frame = '0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_vaddr = '0;
    logic        req_store = 1'b0;
    logic        req_user = 1'b0;
    logic        mem_req_valid, mem_req_write;
    logic [31:0] mem_req_addr, mem_req_wdata;
    logic        mem_gnt;
    logic        mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_rdata = '0;
    logic        done_valid;
    logic [31:0] done_paddr;
    logic [1:0]  done_fault;

    always #10 clk = ~clk;

    pt_walker u0 (
        .clk(clk), .rst_n(rst_n), .root_we(root_we), .root_frame(root_frame),
        .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
        .req_store(req_store), .req_user(req_user),
        .mem_req_valid(mem_req_valid), .mem_req_write(mem_req_write),
        .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata),
        .mem_gnt(mem_gnt), .mem_rsp_valid(mem_rsp_valid), .mem_rsp_rdata(mem_rsp_rdata),
        .done_valid(done_valid), .done_paddr(done_paddr), .done_fault(done_fault)
    );

    // memory model: answers one cycle after grant
    logic [31:0] mem [0:4095];
    logic        pl_we = 1'b0;
    logic [31:0] pl_addr = '0, pl_data = '0;
    logic        gnt_full = 1'b1;
    logic        phase = 1'b0;
    int          n_rd = 0, n_wr = 0;
    logic [31:0] last_ra = '0, prev_ra = '0, last_wa = '0, last_wd = '0;

    assign mem_gnt = gnt_full | phase;

    always @(posedge clk) begin
        phase <= ~phase;
        mem_rsp_valid <= 1'b0;
        if (pl_we) mem[pl_addr[13:2]] <= pl_data;
        if (mem_req_valid && mem_gnt) begin
            mem_rsp_valid <= 1'b1;
            if (mem_req_write) begin
                mem[mem_req_addr[13:2]] <= mem_req_wdata;
                n_wr    <= n_wr + 1;
                last_wa <= mem_req_addr;
                last_wd <= mem_req_wdata;
                mem_rsp_rdata <= '0;
            end else begin
                mem_rsp_rdata <= mem[mem_req_addr[13:2]];
                n_rd    <= n_rd + 1;
                prev_ra <= last_ra;
                last_ra <= mem_req_addr;
            end
        end
    end

    int n_chk = 0, n_fail = 0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic preload(input logic [31:0] a, input logic [31:0] d);
        @(negedge clk);
        pl_we = 1'b1; pl_addr = a; pl_data = d;
        @(negedge clk);
        pl_we = 1'b0;
    endtask

    task automatic set_root(input logic [19:0] f);
        @(negedge clk);
        root_we = 1'b1; root_frame = f;
        @(negedge clk);
        root_we = 1'b0;
    endtask

    task automatic walk(input logic [31:0] va, input logic st, input logic us,
                        output logic [31:0] pa, output logic [1:0] flt,
                        output int rd, output int wr);
        int r0, w0, lim;
        @(negedge clk);
        lim = 0;
        while (!req_ready && lim < 500) begin @(negedge clk); lim++; end
        r0 = n_rd; w0 = n_wr;
        req_valid = 1'b1; req_vaddr = va; req_store = st; req_user = us;
        @(negedge clk);
        req_valid = 1'b0;
        lim = 0;
        while (!done_valid && lim < 500) begin @(negedge clk); lim++; end
        if (!done_valid) chk("R11 walk completes", 32'd0, 32'd1);
        pa = done_paddr; flt = done_fault;
        rd = n_rd - r0; wr = n_wr - w0;
    endtask

    task automatic t_reset();
        chk("R1 req_ready", 32'(req_ready), 32'd1);
        chk("R1 mem_req_valid", 32'(mem_req_valid), 32'd0);
        chk("R1 done_valid", 32'(done_valid), 32'd0);
    endtask

    task automatic t_small_load_stalled();
        logic [31:0] pa; logic [1:0] f; int rd, wr;
        gnt_full = 1'b0;
        walk(32'h0000_5ABC, 1'b0, 1'b1, pa, f, rd, wr);
        gnt_full = 1'b1;
        chk("R2 dir addr", prev_ra, 32'h0000_1000);
        chk("R3 leaf addr", last_ra, 32'h0000_2014);
        chk("R4 paddr", pa, 32'h1234_5ABC);
        chk("R4 fault", 32'(f), 32'd0);
        chk("R12 reads", 32'(rd), 32'd2);
        chk("R9 writes", 32'(wr), 32'd1);
        chk("R9 wb addr", last_wa, 32'h0000_2014);
        chk("R9 wb data load", last_wd, 32'h1234_5027);
    endtask

    task automatic t_small_store();
        logic [31:0] pa; logic [1:0] f; int rd, wr;
        walk(32'h0000_5ABC, 1'b1, 1'b1, pa, f, rd, wr);
        chk("R4 store paddr", pa, 32'h1234_5ABC);
        chk("R9 wb data store dirty", last_wd, 32'h1234_5067);
    endtask

    task automatic t_large();
        logic [31:0] pa; logic [1:0] f; int rd, wr;
        walk(32'h0041_2345, 1'b0, 1'b1, pa, f, rd, wr);
        chk("R5 paddr", pa, 32'hABC1_2345);
        chk("R5 single read", 32'(rd), 32'd1);
        chk("R2 dir addr idx1", last_ra, 32'h0000_1004);
        chk("R9 large wb addr", last_wa, 32'h0000_1004);
        chk("R9 large wb data", last_wd, 32'hABC0_00A7);
    endtask

    task automatic t_absent();
        logic [31:0] pa; logic [1:0] f; int rd, wr;
        walk(32'h0080_0000, 1'b0, 1'b0, pa, f, rd, wr);
        chk("R6 dir absent fault", 32'(f), 32'd1);
        chk("R6 dir absent reads", 32'(rd), 32'd1);
        chk("R10 dir absent writes", 32'(wr), 32'd0);
        chk("R10 dir absent paddr", pa, 32'd0);
        walk(32'h0000_8000, 1'b0, 1'b0, pa, f, rd, wr);
        chk("R6 leaf absent fault", 32'(f), 32'd1);
        chk("R6 leaf absent reads", 32'(rd), 32'd2);
        chk("R10 leaf absent writes", 32'(wr), 32'd0);
    endtask

    task automatic t_write_prot();
        logic [31:0] pa; logic [1:0] f; int rd, wr;
        walk(32'h0000_6004, 1'b1, 1'b1, pa, f, rd, wr);
        chk("R8 store readonly fault", 32'(f), 32'd2);
        chk("R10 store readonly writes", 32'(wr), 32'd0);
        walk(32'h0000_6004, 1'b0, 1'b1, pa, f, rd, wr);
        chk("R8 load readonly ok", 32'(f), 32'd0);
        chk("R4 load readonly paddr", pa, 32'h2345_6004);
    endtask

    task automatic t_user_prot();
        logic [31:0] pa; logic [1:0] f; int rd, wr;
        walk(32'h0000_7000, 1'b0, 1'b1, pa, f, rd, wr);
        chk("R7 user fault", 32'(f), 32'd3);
        walk(32'h0000_7000, 1'b1, 1'b0, pa, f, rd, wr);
        chk("R7 supervisor ok", 32'(f), 32'd0);
        chk("R4 supervisor paddr", pa, 32'h3456_7000);
        chk("R9 supervisor store wb", last_wd, 32'h3456_7063);
        walk(32'h0000_9000, 1'b1, 1'b1, pa, f, rd, wr);
        chk("R7 user over write priority", 32'(f), 32'd3);
    endtask

    task automatic t_busy();
        int r0, lim;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        r0 = n_rd;
        req_valid = 1'b1; req_vaddr = 32'h0000_5ABC; req_store = 1'b0; req_user = 1'b0;
        @(negedge clk);
        chk("R11 not ready while busy", 32'(req_ready), 32'd0);
        req_vaddr = 32'h0041_2345;
        lim = 0;
        while (!done_valid && lim < 500) begin @(negedge clk); lim++; end
        chk("R11 first request result", done_paddr, 32'h1234_5ABC);
        req_valid = 1'b0;
        chk("R11 reads of one walk", 32'(n_rd - r0), 32'd2);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk("R11 idle no request", 32'(mem_req_valid), 32'd0);
        end
        chk("R11 idle ready", 32'(req_ready), 32'd1);
    endtask

    task automatic t_root();
        logic [31:0] pa; logic [1:0] f; int rd, wr;
        set_root(20'h00003);
        walk(32'h0000_5123, 1'b0, 1'b0, pa, f, rd, wr);
        chk("R13 new root dir addr", last_ra, 32'h0000_3000);
        chk("R13 new root paddr", pa, 32'h5540_5123);
        set_root(20'h00001);
        walk(32'h0000_5123, 1'b0, 1'b0, pa, f, rd, wr);
        chk("R13 restored root paddr", pa, 32'h1234_5123);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        preload(32'h0000_1000, 32'h0000_2001);
        preload(32'h0000_1004, 32'hABC0_0087);
        preload(32'h0000_1008, 32'h0000_0000);
        preload(32'h0000_2014, 32'h1234_5007);
        preload(32'h0000_2018, 32'h2345_6005);
        preload(32'h0000_201C, 32'h3456_7003);
        preload(32'h0000_2020, 32'h0000_0000);
        preload(32'h0000_2024, 32'h4567_8001);
        preload(32'h0000_3000, 32'h5540_0087);
        set_root(20'h00001);
        t_small_load_stalled();
        t_small_store();
        t_large();
        t_absent();
        t_write_prot();
        t_user_prot();
        t_busy();
        t_root();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule